// File: doc/BRIEF.md
# Display Controller Interrupt Status Unit

This unit keeps the event status, the interrupt mask and the resulting interrupt request of a display refresh controller. The display pipeline sends it single-cycle pulses: a FIFO underrun, a base-address reload at frame start, a vertical-compare match, and the end of a frame's pixel output. A single register write port updates the unit. Each write selects one of four targets: the status word (write-one-to-clear), the mask, the base-address register (only the strobe matters here) or the control word, which holds the enable bit.

Every status bit is gated by its mask bit. One registered request line is raised when any gated bit is set. The parameter `GRACEFUL` picks how a disable takes effect. With 1, the controller keeps running until the current frame has been fully clocked out, then stops and raises the done bit. With 0, it stops in the cycle the enable bit is cleared, and no done bit exists.

Top module: `disp_irq_status`

## Requirements
- R1: After reset, `status`, `mask`, `irq_bits`, `irq` and `active` are all zero.
- R2: The status, mask and `irq_bits` words share one layout: bit 0 is underrun, bit 1 is next-base loaded, bit 2 is vertical compare and bit 3 is frame done. Each event pulse sets its bit in the next cycle.
- R3: The underrun and vertical-compare bits are sticky. They clear only on a status write (`wr_sel`=0) with a 1 in their position. Written 0s have no effect.
- R4: The next-base bit clears on any base-address write (`wr_sel`=2). A status write has no effect on it.
- R5: The mask is written with `wr_sel`=1 from `wr_data[3:0]`. `irq_bits` equals `status & mask`.
- R6: `irq` is registered. It equals the OR of `irq_bits` from the previous cycle.
- R7: With `GRACEFUL`=1, `active` stays high after the enable bit is cleared. On the next `ev_frame_end`, `active` drops and the done bit sets. A frame end while enabled sets nothing.
- R8: The done bit clears on a base-address write, on a control write (`wr_sel`=3) with `wr_data[0]`=1, or on a status write with bit 3 set.
- R9: When a hardware set and a software clear of the same bit occur in one cycle, the bit ends set.
- R10: With `GRACEFUL`=0, `active` drops in the cycle after the control write that clears enable. Status bit 3 is always 0.
- R11: `active` is high in the cycle after a control write with `wr_data[0]`=1, in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_underrun | input | 1 | FIFO underrun pulse |
| ev_reload | input | 1 | Base address copied to current address |
| ev_vmatch | input | 1 | Vertical region reached |
| ev_frame_end | input | 1 | Last pixels of a frame clocked out |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Target: 0 status, 1 mask, 2 base address, 3 control |
| wr_data | input | 4 | Write data (control enable in bit 0) |
| status | output | 4 | Status bits |
| mask | output | 4 | Mask bits |
| irq_bits | output | 4 | Status AND mask |
| irq | output | 1 | Registered interrupt request |
| active | output | 1 | Controller running flag |

## Verification
The bench builds two copies of the unit, one with `GRACEFUL`=1 and one with `GRACEFUL`=0, and drives both with the same stimulus. The graceful copy shows the deferred stop on the frame-end pulse and all three ways the done bit can be cleared. The immediate copy shows the stop in the same cycle as the write, and that bit 3 stays 0 across the same frame ends.

// File: rtl/disp_irq_status.sv
module disp_irq_status #(
  parameter bit GRACEFUL = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_underrun,
  input  logic       ev_reload,
  input  logic       ev_vmatch,
  input  logic       ev_frame_end,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic [3:0] wr_data,
  output logic [3:0] status,
  output logic [3:0] mask,
  output logic [3:0] irq_bits,
  output logic       irq,
  output logic       active
);
  logic ctl_en;

  wire w_st   = wr_en && wr_sel == 2'd0;
  wire w_mask = wr_en && wr_sel == 2'd1;
  wire w_base = wr_en && wr_sel == 2'd2;
  wire w_ctl  = wr_en && wr_sel == 2'd3;

  wire en_set = w_ctl && wr_data[0];
  wire en_eff = w_ctl ? wr_data[0] : ctl_en;
  wire stop_g = active && !en_eff && ev_frame_end;
  wire done_set = GRACEFUL && stop_g;

  wire act_nxt = GRACEFUL ? (en_set ? 1'b1 : (stop_g ? 1'b0 : active)) : en_eff;

  wire [3:0] st_nxt;
  assign st_nxt[0] = ev_underrun | (status[0] & ~(w_st & wr_data[0]));
  assign st_nxt[1] = ev_reload | (status[1] & ~w_base);
  assign st_nxt[2] = ev_vmatch | (status[2] & ~(w_st & wr_data[2]));
  assign st_nxt[3] = done_set | (status[3] & ~(w_st & wr_data[3]) & ~w_base & ~en_set);

  assign irq_bits = status & mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= 4'd0;
      mask   <= 4'd0;
      irq    <= 1'b0;
      active <= 1'b0;
      ctl_en <= 1'b0;
    end else begin
      status <= st_nxt;
      if (w_mask) mask <= wr_data;
      irq    <= |irq_bits;
      active <= act_nxt;
      if (w_ctl) ctl_en <= wr_data[0];
    end
  end
endmodule

module disp_irq_status_chk #(
  parameter bit GRACEFUL = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ev_underrun,
  input logic       ev_reload,
  input logic       wr_en,
  input logic [1:0] wr_sel,
  input logic [3:0] wr_data,
  input logic [3:0] status,
  input logic [3:0] mask,
  input logic       irq,
  input logic       active
);
  // R6
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(status & mask)) |=> irq);
  // R6
  irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(status & mask)) |=> !irq);
  // R3
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && !(wr_en && wr_sel == 2'd0 && wr_data[0])) |=> status[0]);
  // R9
  underrun_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_underrun |=> status[0]);
  // R4
  next_base_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd2 && !ev_reload) |=> !status[1]);
  // R11
  enable_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd3 && wr_data[0]) |=> active);
  // R10
  always_comb if (!GRACEFUL) no_done_bit_chk: assert (status[3] == 1'b0);
endmodule

bind disp_irq_status disp_irq_status_chk #(.GRACEFUL(GRACEFUL)) chk_i (
  .clk(clk), .rst_n(rst_n), .ev_underrun(ev_underrun), .ev_reload(ev_reload),
  .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .status(status),
  .mask(mask), .irq(irq), .active(active)
);

// File: tb/disp_irq_status_test.sv
module disp_irq_status_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] ev = 4'd0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [3:0] wr_data = 4'd0;
  logic [3:0] st_g, mk_g, ib_g, st_i, mk_i, ib_i;
  logic irq_g, act_g, irq_i, act_i;
  int checks = 0, fails = 0;
  bit done_flag = 1'b0;

  always #5 clk = ~clk;

  disp_irq_status #(.GRACEFUL(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .ev_underrun(ev[0]), .ev_reload(ev[1]),
    .ev_vmatch(ev[2]), .ev_frame_end(ev[3]), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .status(st_g), .mask(mk_g), .irq_bits(ib_g),
    .irq(irq_g), .active(act_g));

  disp_irq_status #(.GRACEFUL(1'b0)) uut_imm (
    .clk(clk), .rst_n(rst_n), .ev_underrun(ev[0]), .ev_reload(ev[1]),
    .ev_vmatch(ev[2]), .ev_frame_end(ev[3]), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .status(st_i), .mask(mk_i), .irq_bits(ib_i),
    .irq(irq_i), .active(act_i));

  // {frame_end,vmatch,reload,underrun}, wr_en, wr_sel, wr_data, exp status, exp mask
  localparam int NV = 17;
  localparam logic [18:0] VEC [NV] = '{
    {4'b0001, 1'b0, 2'd0, 4'b0000, 4'b0001, 4'b0000},
    {4'b0000, 1'b0, 2'd0, 4'b0000, 4'b0001, 4'b0000},
    {4'b0000, 1'b1, 2'd0, 4'b0000, 4'b0001, 4'b0000},
    {4'b0000, 1'b1, 2'd1, 4'b1111, 4'b0001, 4'b1111},
    {4'b0000, 1'b1, 2'd0, 4'b0001, 4'b0000, 4'b1111},
    {4'b0100, 1'b0, 2'd0, 4'b0000, 4'b0100, 4'b1111},
    {4'b0010, 1'b0, 2'd0, 4'b0000, 4'b0110, 4'b1111},
    {4'b0000, 1'b1, 2'd0, 4'b0010, 4'b0110, 4'b1111},
    {4'b0000, 1'b1, 2'd2, 4'b0000, 4'b0100, 4'b1111},
    {4'b0000, 1'b1, 2'd0, 4'b0100, 4'b0000, 4'b1111},
    {4'b0001, 1'b1, 2'd0, 4'b0001, 4'b0001, 4'b1111},
    {4'b0000, 1'b1, 2'd0, 4'b0001, 4'b0000, 4'b1111},
    {4'b0000, 1'b1, 2'd1, 4'b0010, 4'b0000, 4'b0010},
    {4'b0001, 1'b0, 2'd0, 4'b0000, 4'b0001, 4'b0010},
    {4'b0010, 1'b0, 2'd0, 4'b0000, 4'b0011, 4'b0010},
    {4'b0000, 1'b1, 2'd0, 4'b0001, 4'b0010, 4'b0010},
    {4'b0000, 1'b1, 2'd2, 4'b0000, 4'b0000, 4'b0010}
  };

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] e, input logic we, input logic [1:0] sel,
                      input logic [3:0] d);
    @(negedge clk);
    ev = e; wr_en = we; wr_sel = sel; wr_data = d;
    @(posedge clk);
    #1;
    ev = 4'd0; wr_en = 1'b0; wr_sel = 2'd0; wr_data = 4'd0;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [3:0] prev_st, prev_mk;
    repeat (3) @(posedge clk);
    #1;
    // R1
    chk("R1 status", st_g, 4'd0);
    chk("R1 mask", mk_g, 4'd0);
    chk("R1 irq/active", {2'b00, irq_g, act_g}, 4'd0);
    @(negedge clk) rst_n = 1'b1;
    prev_st = 4'd0; prev_mk = 4'd0;
    // R2 R3 R4 R5 R6 R9 vector walk
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][18:15], VEC[i][14], VEC[i][13:12], VEC[i][11:8]);
      chk("R2/R3/R4/R9 status", st_g, VEC[i][7:4]);
      chk("R5 mask", mk_g, VEC[i][3:0]);
      chk("R5 irq_bits", ib_g, VEC[i][7:4] & VEC[i][3:0]);
      chk("R6 irq", {3'b000, irq_g}, {3'b000, |(prev_st & prev_mk)});
      prev_st = VEC[i][7:4]; prev_mk = VEC[i][3:0];
    end

    @(negedge clk) rst_n = 1'b0;
    @(posedge clk); #1;
    chk("R1 reset again", {st_g, mk_g}, 8'd0);
    chk("R1 imm active", {3'b000, act_i}, 4'd0);
    @(negedge clk) rst_n = 1'b1;

    step(4'b0000, 1'b1, 2'd3, 4'b0001);
    chk("R11 graceful active", {3'b000, act_g}, 4'd1);
    chk("R11 immediate active", {3'b000, act_i}, 4'd1);
    step(4'b1000, 1'b0, 2'd0, 4'b0000);
    chk("R7 frame end while enabled", {st_g[3], 2'b00, act_g}, 4'b0001);
    step(4'b0000, 1'b1, 2'd3, 4'b0000);
    chk("R7 still active after disable", {3'b000, act_g}, 4'd1);
    chk("R10 immediate stop", {3'b000, act_i}, 4'd0);
    step(4'b0000, 1'b0, 2'd0, 4'b0000);
    chk("R7 active waits", {3'b000, act_g}, 4'd1);
    step(4'b1000, 1'b0, 2'd0, 4'b0000);
    chk("R7 stop and done", {st_g[3], 2'b00, act_g}, 4'b1000);
    chk("R10 no done bit", st_i, 4'd0);
    step(4'b0000, 1'b1, 2'd0, 4'b1000);
    chk("R8 w1c done", st_g, 4'd0);

    step(4'b0000, 1'b1, 2'd3, 4'b0001);
    step(4'b0000, 1'b1, 2'd3, 4'b0000);
    step(4'b1000, 1'b0, 2'd0, 4'b0000);
    chk("R7 done again", st_g, 4'b1000);
    step(4'b0000, 1'b1, 2'd2, 4'b0000);
    chk("R8 base write clears done", st_g, 4'd0);

    step(4'b0000, 1'b1, 2'd3, 4'b0001);
    step(4'b0000, 1'b1, 2'd3, 4'b0000);
    step(4'b1000, 1'b0, 2'd0, 4'b0000);
    step(4'b0000, 1'b1, 2'd3, 4'b0001);
    chk("R8 enable clears done", {st_g[3], 2'b00, act_g}, 4'b0001);

    step(4'b0000, 1'b1, 2'd3, 4'b0000);
    step(4'b1000, 1'b1, 2'd0, 4'b1000);
    chk("R9 done set beats w1c", st_g, 4'b1000);
    step(4'b0000, 1'b1, 2'd1, 4'b1000);
    step(4'b0000, 1'b0, 2'd0, 4'b0000);
    chk("R6 irq from done", {3'b000, irq_g}, 4'd1);
    chk("R10 immediate irq quiet", {3'b000, irq_i}, 4'd0);

    finish_run();
  end
endmodule